// File: doc/BRIEF.md
# Boundary-Scan Pin Cell Chain

This block is the boundary register that sits between a chip's core and its bidirectional pads. Each pad gets three serial cells. One observes the value arriving at the pad. One holds the data the pad should drive. One holds the pad's driver enable, which is active low. Test equipment first grabs a snapshot into these cells and shifts it out for comparison. It then shifts in a new pattern and commits it to a set of update latches. The shifting takes place on the test clock under the capture, shift and update strobes that a test access port controller produces.

Four mode selects control how the pads are driven. In observe/preload mode the core keeps control of the pads while the chain samples them and may be preloaded. In external-test mode the update latches drive the pads. In float mode every driver is switched off. In hold mode the pads keep the update latch values. In the last two modes the chain is out of the serial path, so it ignores every strobe. The cell count is set by a pin-count parameter. The default of 200 pins gives a 600-cell chain.

Top module: `bscan_pin_chain`

## Requirements
- R1: While `rst_n` is low and after it is released, the shift chain is all zero, so `tdo` is 0. The update latches hold data 0 and enable 1, which means the driver is off.
- R2: When neither external-test, float nor hold is selected, `pad_dout` equals `core_dout` and `pad_oe_n` equals `core_oe_n`, whatever the strobes do.
- R3: A `capture_dr` edge with the chain selected (observe/preload or external-test, with neither float nor hold) loads each pin's three cells. Cell 3i gets `pin_in[i]`, cell 3i+1 gets `core_dout[i]` and cell 3i+2 gets `core_oe_n[i]`.
- R4: `tdo` always shows cell 0. Each `shift_dr` edge with the chain selected moves every cell one place toward cell 0 and loads `tdi` into the last cell. The first bit shifted in therefore lands in cell 0 after 3*NUM_PINS shifts. If strobes coincide, capture wins over shift, and shift wins over update.
- R5: The update latches change only on an `update_dr` edge with the chain selected. At that edge pin i's data latch takes cell 3i+1 and its enable latch takes cell 3i+2. Pad outputs driven from the latches do not move while shifting.
- R6: In external-test mode, `pad_dout` and `pad_oe_n` equal the update latches. An enable latch value of 0 means the pad drives the data latch value.
- R7: Float mode overrides every other select. It forces `pad_oe_n` to all ones and `pad_dout` to all zeros.
- R8: In hold mode without float, the pads follow the update latches.
- R9: In float mode, in hold mode, or when no scan mode is selected, capture, shift and update strobes change neither the chain nor the update latches.
- R10: A pattern preloaded and updated in observe/preload mode appears on the pads as soon as external-test is selected, without any further update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low test logic reset |
| tdi | input | 1 | Serial data into the far end of the chain |
| tdo | output | 1 | Serial data from cell 0 |
| capture_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Update strobe |
| mode_sample | input | 1 | Observe/preload mode select |
| mode_extest | input | 1 | External-test mode select |
| mode_highz | input | 1 | Float mode select |
| mode_clamp | input | 1 | Hold mode select |
| pin_in | input | NUM_PINS | Values seen at the pads |
| core_dout | input | NUM_PINS | Output data from the core |
| core_oe_n | input | NUM_PINS | Active-low output enable from the core |
| pad_dout | output | NUM_PINS | Output data to the pads |
| pad_oe_n | output | NUM_PINS | Active-low output enable to the pads |

## Verification
A chain cell that is lost or out of order shows up on `tdo` as a bit at the wrong position of the shifted-out vector. It appears within one full chain length after the capture that filled it. A wrong update latch stays hidden while the core drives the pads. It appears on the pad outputs in the same cycle that external-test or hold is selected, which is why preloaded values are checked at that moment. A strobe that leaks through in a bypassed mode only shows once a later scan or hold exposes the corrupted state, so the bench always reads the state back after such stimulus.

// File: rtl/bscan_pin_chain.sv
module bscan_pin_chain #(
  parameter int NUM_PINS = 200,
  localparam int CHAIN_LEN = 3 * NUM_PINS
) (
  input  logic                tck,
  input  logic                rst_n,
  input  logic                tdi,
  output logic                tdo,
  input  logic                capture_dr,
  input  logic                shift_dr,
  input  logic                update_dr,
  input  logic                mode_sample,
  input  logic                mode_extest,
  input  logic                mode_highz,
  input  logic                mode_clamp,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [NUM_PINS-1:0] core_dout,
  input  logic [NUM_PINS-1:0] core_oe_n,
  output logic [NUM_PINS-1:0] pad_dout,
  output logic [NUM_PINS-1:0] pad_oe_n
);

  logic [CHAIN_LEN-1:0] chain, cap_vec;
  logic [NUM_PINS-1:0]  upd_out, upd_oe_n;
  logic                 chain_sel, drive_upd;

  assign chain_sel = (mode_sample | mode_extest) & ~mode_highz & ~mode_clamp;
  assign drive_upd = ~mode_highz & (mode_clamp | mode_extest);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    assign cap_vec[3*i]   = pin_in[i];
    assign cap_vec[3*i+1] = core_dout[i];
    assign cap_vec[3*i+2] = core_oe_n[i];

    always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
        upd_out[i]  <= 1'b0;
        upd_oe_n[i] <= 1'b1;
      end else if (chain_sel && update_dr && !capture_dr && !shift_dr) begin
        upd_out[i]  <= chain[3*i+1];
        upd_oe_n[i] <= chain[3*i+2];
      end
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)
      chain <= '0;
    else if (chain_sel && capture_dr)
      chain <= cap_vec;
    else if (chain_sel && shift_dr)
      chain <= {tdi, chain[CHAIN_LEN-1:1]};
  end

  assign tdo      = chain[0];
  assign pad_oe_n = mode_highz ? '1 : (drive_upd ? upd_oe_n : core_oe_n);
  assign pad_dout = mode_highz ? '0 : (drive_upd ? upd_out  : core_dout);

endmodule

// File: rtl/bscan_pin_chain_chk.sv
module bscan_pin_chain_chk #(
  parameter int NUM_PINS = 200,
  localparam int CHAIN_LEN = 3 * NUM_PINS
) (
  input logic                 tck,
  input logic                 rst_n,
  input logic                 tdo,
  input logic                 capture_dr,
  input logic                 shift_dr,
  input logic                 update_dr,
  input logic                 mode_sample,
  input logic                 mode_extest,
  input logic                 mode_highz,
  input logic                 mode_clamp,
  input logic [NUM_PINS-1:0]  pin_in,
  input logic [NUM_PINS-1:0]  core_dout,
  input logic [NUM_PINS-1:0]  core_oe_n,
  input logic [NUM_PINS-1:0]  pad_dout,
  input logic [NUM_PINS-1:0]  pad_oe_n,
  input logic [CHAIN_LEN-1:0] chain,
  input logic [NUM_PINS-1:0]  upd_out,
  input logic [NUM_PINS-1:0]  upd_oe_n
);
  logic sel;
  assign sel = (mode_sample | mode_extest) & ~mode_highz & ~mode_clamp;

  a_r3_capture_pin0: assert property (@(posedge tck) disable iff (!rst_n)
    (sel && capture_dr) |=> (chain[0] == $past(pin_in[0]) && chain[1] == $past(core_dout[0])
                             && chain[2] == $past(core_oe_n[0])));

  a_r4_shift_toward_tdo: assert property (@(posedge tck) disable iff (!rst_n)
    (sel && shift_dr && !capture_dr) |=> (tdo == $past(chain[1])));

  a_r5_update_only_on_strobe: assert property (@(posedge tck) disable iff (!rst_n)
    !(sel && update_dr) |=> ($stable(upd_out) && $stable(upd_oe_n)));

  a_r7_highz_drivers_off: assert property (@(posedge tck) disable iff (!rst_n)
    mode_highz |-> (&pad_oe_n));

  a_r9_chain_frozen_when_bypassed: assert property (@(posedge tck) disable iff (!rst_n)
    !sel |=> $stable(chain));

  a_r2_core_passthrough: assert property (@(posedge tck) disable iff (!rst_n)
    (!mode_highz && !mode_clamp && !mode_extest) |-> (pad_dout == core_dout && pad_oe_n == core_oe_n));
endmodule

bind bscan_pin_chain bscan_pin_chain_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .tck(tck), .rst_n(rst_n), .tdo(tdo), .capture_dr(capture_dr), .shift_dr(shift_dr),
  .update_dr(update_dr), .mode_sample(mode_sample), .mode_extest(mode_extest),
  .mode_highz(mode_highz), .mode_clamp(mode_clamp), .pin_in(pin_in), .core_dout(core_dout),
  .core_oe_n(core_oe_n), .pad_dout(pad_dout), .pad_oe_n(pad_oe_n), .chain(chain),
  .upd_out(upd_out), .upd_oe_n(upd_oe_n)
);

// File: tb/bscan_pin_chain_tb.sv
module bscan_pin_chain_tb;
  localparam int NP = 4;
  localparam int L  = 3 * NP;

  logic tck = 1'b0, rst_n = 1'b0, tdi = 1'b0, tdo;
  logic capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
  logic mode_sample = 1'b0, mode_extest = 1'b0, mode_highz = 1'b0, mode_clamp = 1'b0;
  logic [NP-1:0] pin_in = '0, core_dout = '0, core_oe_n = '1, pad_dout, pad_oe_n;
  int checks = 0, errors = 0;
  logic [L-1:0] exp_chain;
  logic [NP-1:0] exp_out, exp_oe;

  always #10 tck = ~tck;

  bscan_pin_chain #(.NUM_PINS(NP)) u_dut (.*);

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [L-1:0] pack(logic [NP-1:0] p, logic [NP-1:0] d, logic [NP-1:0] o);
    logic [L-1:0] v;
    for (int i = 0; i < NP; i++) begin
      v[3*i] = p[i]; v[3*i+1] = d[i]; v[3*i+2] = o[i];
    end
    return v;
  endfunction

  task automatic pulse(input int which);
    capture_dr = (which == 0); shift_dr = (which == 1); update_dr = (which == 2);
    @(posedge tck); @(negedge tck);
    capture_dr = 0; shift_dr = 0; update_dr = 0;
  endtask

  task automatic scan(input logic [L-1:0] din, output logic [L-1:0] dout);
    for (int k = 0; k < L; k++) begin
      dout[k] = tdo;
      tdi = din[k];
      pulse(1);
    end
  endtask

  task automatic set_mode(logic s, logic e, logic h, logic c);
    mode_sample = s; mode_extest = e; mode_highz = h; mode_clamp = c;
    #1;
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (2) @(negedge tck);
    chk("R1 tdo in reset", 32'(tdo), 0);
    rst_n = 1;
    @(negedge tck);
    chk("R1 tdo after reset", 32'(tdo), 0);
    set_mode(0, 0, 0, 1);
    chk("R1 latch data", 32'(pad_dout), 0);
    chk("R1 latch enable", 32'(pad_oe_n), 32'({NP{1'b1}}));
    set_mode(0, 0, 0, 0);
  endtask

  task automatic t_passthrough();
    core_dout = 4'b1010; core_oe_n = 4'b0110; #1;
    chk("R2 dout idle", 32'(pad_dout), 32'(4'b1010));
    chk("R2 oe idle", 32'(pad_oe_n), 32'(4'b0110));
    set_mode(1, 0, 0, 0);
    core_dout = 4'b0101; core_oe_n = 4'b1001; pulse(2);
    chk("R2 dout sample", 32'(pad_dout), 32'(4'b0101));
    chk("R2 oe sample", 32'(pad_oe_n), 32'(4'b1001));
  endtask

  task automatic t_sample_preload();
    logic [L-1:0] got, pre;
    pin_in = 4'b1100; core_dout = 4'b0110; core_oe_n = 4'b0011;
    set_mode(1, 0, 0, 0);
    pulse(0);
    exp_chain = pack(4'b1100, 4'b0110, 4'b0011);
    exp_out = 4'b1001; exp_oe = 4'b0100;
    pre = pack(4'b0000, exp_out, exp_oe);
    scan(pre, got);
    chk("R3 R4 captured vector", 32'(got), 32'(exp_chain));
    chk("R2 core drives during preload", 32'(pad_dout), 32'(4'b0110));
    pulse(2);
    set_mode(0, 1, 0, 0);
    chk("R10 R6 preload dout", 32'(pad_dout), 32'(exp_out));
    chk("R10 R6 preload oe", 32'(pad_oe_n), 32'(exp_oe));
  endtask

  task automatic t_extest();
    logic [L-1:0] got, nxt;
    logic [L-1:0] half;
    pin_in = 4'b0011; pulse(0);
    nxt = pack(4'b1111, 4'b0111, 4'b1010);
    half = '0;
    for (int k = 0; k < L/2; k++) begin
      half[k] = tdo; tdi = nxt[k]; pulse(1);
    end
    chk("R5 dout stable mid-shift", 32'(pad_dout), 32'(exp_out));
    chk("R5 oe stable mid-shift", 32'(pad_oe_n), 32'(exp_oe));
    for (int k = L/2; k < L; k++) begin
      half[k] = tdo; tdi = nxt[k]; pulse(1);
    end
    chk("R3 extest capture", 32'(half), 32'(pack(4'b0011, core_dout, core_oe_n)));
    pulse(2);
    exp_out = 4'b0111; exp_oe = 4'b1010; exp_chain = nxt;
    chk("R6 dout after update", 32'(pad_dout), 32'(exp_out));
    chk("R6 oe after update", 32'(pad_oe_n), 32'(exp_oe));
  endtask

  task automatic t_highz_clamp();
    logic [L-1:0] got;
    set_mode(0, 1, 1, 0);
    chk("R7 highz oe", 32'(pad_oe_n), 32'(4'b1111));
    chk("R7 highz dout", 32'(pad_dout), 0);
    tdi = 1; pulse(0); pulse(1); pulse(2);
    set_mode(0, 0, 0, 1);
    chk("R8 R9 clamp dout", 32'(pad_dout), 32'(exp_out));
    chk("R8 R9 clamp oe", 32'(pad_oe_n), 32'(exp_oe));
    tdi = 1; pulse(0); pulse(1); pulse(2);
    set_mode(0, 0, 0, 0);
    pulse(1); pulse(0);
    set_mode(0, 0, 0, 1);
    chk("R9 clamp dout after ignored strobes", 32'(pad_dout), 32'(exp_out));
    set_mode(1, 0, 0, 0);
    scan('0, got);
    chk("R9 chain untouched", 32'(got), 32'(exp_chain));
  endtask

  initial begin
    #1;
    t_reset();
    t_passthrough();
    t_sample_preload();
    t_extest();
    t_highz_clamp();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule